// File: doc/BRIEF.md
# External Interrupt Pin Decoder

This block watches eight active-low external interrupt pins and one active-low non-maskable interrupt pin, and turns them into a single presented interrupt request for a processor core. Each request carries an 8-bit vector number, a source code and a flag that marks the non-maskable source. The core accepts the presented request by pulsing an acknowledge input.

A two-bit mode input decides how the eight pins are read. In dedicated mode every pin is its own source, and a per-pin select picks low-level or falling-edge triggering. Each pin then maps to a vector taken from a programmable table. In expanded mode the eight pins together are one level-sensitive vector port, and the requested vector is the bitwise inverse of the pin value. In mixed mode the three top pins stay dedicated, and the five low pins give the upper five vector bits below which the block appends the constant bits 010. Every pin passes through a two-stage synchronizer before any edge or level decision. The non-maskable pin is edge-triggered and always wins.

Top module: `ext_irq_decoder`

## Requirements
- R1: After reset, all synchronizer stages read as inactive (high), no edge latch is set and `req_valid_o` is 0.
- R2: A pin level driven before clock edge k is seen as a level after edge k+1 and as a falling edge (latched) after edge k+2; the presented outputs are combinational from that state.
- R3: A dedicated pin with its `edge_sel_i` bit at 0 requests while its synchronized level is low and stops requesting as soon as it reads high, and its vector is `vec_tbl_i[8*i +: 8]` with source code i.
- R4: A dedicated pin with its `edge_sel_i` bit at 1 latches a request on a synchronized high-to-low transition, and the request stays pending after the pin returns high.
- R5: `ack_i` while `req_valid_o` is 1 clears only the latch of the presented edge source; a level source is not cleared by it, and a new falling edge on the same source in the acknowledge cycle keeps the latch set.
- R6: Mode code 1 (expanded) suppresses all dedicated sources and requests source code 8 with vector equal to the inverted synchronized pins; an inverted value of zero means no request.
- R7: Mode code 2 (mixed) keeps pins 7 to 5 as dedicated sources and requests source code 8 with vector {inverted pins 4 to 0, 3'b010} whenever the inverted five bits are nonzero.
- R8: Among pending non-NMI sources, the one with the largest vector value is presented; on equal vectors the larger source code wins (pins 0 to 7, then the vectored source 8).
- R9: A falling edge on `nmi_n_i` latches a request that is presented ahead of all others with source code 9, `req_nmi_o` at 1 and vector `NMI_VECTOR`, and it is cleared only by an acknowledge while it is presented.
- R10: Mode codes 0 and 3 both select dedicated mode, with all eight pins as sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 8 | Asynchronous active-low interrupt pins |
| nmi_n_i | input | 1 | Asynchronous active-low non-maskable pin |
| mode_i | input | 2 | 0/3 dedicated, 1 expanded, 2 mixed |
| edge_sel_i | input | 8 | Per-pin trigger: 1 falling edge, 0 low level |
| vec_tbl_i | input | 64 | Vector for pin i in bits 8*i+7..8*i |
| ack_i | input | 1 | Core accepts the presented request |
| req_valid_o | output | 1 | A request is presented |
| req_nmi_o | output | 1 | Presented request is the non-maskable source |
| req_src_o | output | 4 | Source code: 0-7 pin, 8 vectored port, 9 NMI |
| req_vec_o | output | 8 | Vector number of the presented request |

## Verification
The bench targets the acknowledge path: a design that cleared level sources on acknowledge, or cleared a latch other than the presented one, would lose or drop requests that the model still expects. Arbitration is probed with equal vectors on two sources, where a design breaking ties the wrong way presents the lower source code. The expanded port is driven with all-high pins, which a design without the zero check would report as vector 0, and mixed mode is checked for the appended 010 bits. Synchronizer depth is checked cycle by cycle, so one stage too few or too many shows as a one-cycle shift against the model.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int PIN_N     = 8;
    localparam int VEC_W     = 8;
    localparam int SRC_W     = 4;
    localparam int MIX_DED_N = 3;
    localparam int MIX_HI_N  = PIN_N - MIX_DED_N;
    localparam int MIX_LO_N  = VEC_W - MIX_HI_N;

    localparam logic [MIX_LO_N-1:0] MIX_LOW_BITS = MIX_LO_N'(3'b010);
    localparam logic [SRC_W-1:0]    SRC_VECT     = SRC_W'(PIN_N);
    localparam logic [SRC_W-1:0]    SRC_NMI      = SRC_W'(PIN_N + 1);

    typedef enum logic [1:0] {
        MODE_DED = 2'd0,
        MODE_EXP = 2'd1,
        MODE_MIX = 2'd2,
        MODE_ALT = 2'd3
    } xirq_mode_e;

    typedef struct packed {
        logic             valid;
        logic             nmi;
        logic [SRC_W-1:0] src;
        logic [VEC_W-1:0] vec;
    } xirq_req_t;

    // Which pins act as independent sources in a given mode.
    function automatic logic [PIN_N-1:0] ded_enable(xirq_mode_e m);
        logic [PIN_N-1:0] en;
        case (m)
            MODE_EXP: en = '0;
            MODE_MIX: en = {{MIX_DED_N{1'b1}}, {MIX_HI_N{1'b0}}};
            default:  en = '1;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/xirq_capture.sv
module xirq_capture
    import xirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_N-1:0] sync_i,
    input  logic [PIN_N-1:0] prev_i,
    input  logic [PIN_N-1:0] edge_sel_i,
    input  logic [PIN_N-1:0] en_i,
    input  logic [PIN_N-1:0] clr_i,
    input  logic             nmi_sync_i,
    input  logic             nmi_prev_i,
    input  logic             nmi_clr_i,
    output logic [PIN_N-1:0] pend_o,
    output logic             nmi_pend_o
);
    logic [PIN_N-1:0] pend_q;
    logic             nmi_q;
    logic [PIN_N-1:0] fall;
    logic             nmi_fall;

    assign fall     = prev_i & ~sync_i;
    assign nmi_fall = nmi_prev_i & ~nmi_sync_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            nmi_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | (fall & edge_sel_i & en_i);
            nmi_q  <= (nmi_q & ~nmi_clr_i) | nmi_fall;
        end
    end

    assign pend_o     = pend_q;
    assign nmi_pend_o = nmi_q;

    for (genvar i = 0; i < PIN_N; i++) begin : g_hold
        // R4
        pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    end

    // R9
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_q && !nmi_clr_i) |=> nmi_q);
endmodule

// File: rtl/xirq_arbiter.sv
module xirq_arbiter
    import xirq_pkg::*;
#(
    parameter logic [VEC_W-1:0] NMI_VECTOR = 8'hF8
) (
    input  xirq_mode_e             mode_i,
    input  logic [PIN_N-1:0]       lvl_i,
    input  logic [PIN_N-1:0]       edge_sel_i,
    input  logic [PIN_N-1:0]       pend_i,
    input  logic [PIN_N*VEC_W-1:0] vec_tbl_i,
    input  logic                   nmi_pend_i,
    output logic [PIN_N-1:0]       en_o,
    output xirq_req_t              req_o
);
    logic [PIN_N-1:0]    active;
    logic [PIN_N-1:0]    inv;
    logic                port_pend;
    logic [VEC_W-1:0]    port_vec;

    assign en_o   = ded_enable(mode_i);
    assign inv    = ~lvl_i;
    assign active = en_o & ((edge_sel_i & pend_i) | (~edge_sel_i & inv));

    always_comb begin
        port_pend = 1'b0;
        port_vec  = '0;
        if (mode_i == MODE_EXP) begin
            port_pend = |inv;
            port_vec  = VEC_W'(inv);
        end else if (mode_i == MODE_MIX) begin
            port_pend = |inv[MIX_HI_N-1:0];
            port_vec  = {inv[MIX_HI_N-1:0], MIX_LOW_BITS};
        end
    end

    always_comb begin
        req_o = '0;
        for (int i = 0; i < PIN_N; i++) begin
            if (active[i] && (!req_o.valid || vec_tbl_i[i*VEC_W +: VEC_W] >= req_o.vec)) begin
                req_o.valid = 1'b1;
                req_o.src   = SRC_W'(i);
                req_o.vec   = vec_tbl_i[i*VEC_W +: VEC_W];
            end
        end
        if (port_pend && (!req_o.valid || port_vec >= req_o.vec)) begin
            req_o.valid = 1'b1;
            req_o.src   = SRC_VECT;
            req_o.vec   = port_vec;
        end
        if (nmi_pend_i) begin
            req_o.valid = 1'b1;
            req_o.nmi   = 1'b1;
            req_o.src   = SRC_NMI;
            req_o.vec   = NMI_VECTOR;
        end
    end
endmodule

// File: rtl/ext_irq_decoder.sv
module ext_irq_decoder
    import xirq_pkg::*;
#(
    parameter logic [7:0] NMI_VECTOR = 8'hF8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  irq_n_i,
    input  logic        nmi_n_i,
    input  logic [1:0]  mode_i,
    input  logic [7:0]  edge_sel_i,
    input  logic [63:0] vec_tbl_i,
    input  logic        ack_i,
    output logic        req_valid_o,
    output logic        req_nmi_o,
    output logic [3:0]  req_src_o,
    output logic [7:0]  req_vec_o
);
    xirq_mode_e       mode;
    logic [PIN_N-1:0] lvl, prev, pend, en, clr;
    logic             nmi_lvl, nmi_prev, nmi_pend, nmi_clr;
    xirq_req_t        req;

    assign mode = xirq_mode_e'(mode_i);

    xirq_sync #(.W(PIN_N)) u_pin_sync (
        .clk(clk), .rst(rst), .async_i(irq_n_i), .sync_o(lvl), .prev_o(prev)
    );

    xirq_sync #(.W(1)) u_nmi_sync (
        .clk(clk), .rst(rst), .async_i(nmi_n_i), .sync_o(nmi_lvl), .prev_o(nmi_prev)
    );

    always_comb begin
        for (int i = 0; i < PIN_N; i++)
            clr[i] = ack_i && req.valid && !req.nmi && (req.src == SRC_W'(i));
    end
    assign nmi_clr = ack_i && req.valid && req.nmi;

    xirq_capture u_capture (
        .clk(clk), .rst(rst),
        .sync_i(lvl), .prev_i(prev), .edge_sel_i(edge_sel_i), .en_i(en), .clr_i(clr),
        .nmi_sync_i(nmi_lvl), .nmi_prev_i(nmi_prev), .nmi_clr_i(nmi_clr),
        .pend_o(pend), .nmi_pend_o(nmi_pend)
    );

    xirq_arbiter #(.NMI_VECTOR(NMI_VECTOR)) u_arbiter (
        .mode_i(mode), .lvl_i(lvl), .edge_sel_i(edge_sel_i), .pend_i(pend),
        .vec_tbl_i(vec_tbl_i), .nmi_pend_i(nmi_pend), .en_o(en), .req_o(req)
    );

    assign req_valid_o = req.valid;
    assign req_nmi_o   = req.nmi;
    assign req_src_o   = req.src;
    assign req_vec_o   = req.vec;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req_valid_o);
    // R9
    nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (req_valid_o && req_nmi_o && req_src_o == SRC_NMI));
    // R6
    exp_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_src_o == SRC_VECT && mode == MODE_EXP) |-> (req_vec_o != '0));
    // R6
    exp_no_ded_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && mode == MODE_EXP) |-> (req_src_o >= SRC_VECT));
    // R7
    mix_low_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_src_o == SRC_VECT && mode == MODE_MIX)
            |-> (req_vec_o[MIX_LO_N-1:0] == MIX_LOW_BITS));
endmodule

// File: tb/ext_irq_decoder_tb.sv
module ext_irq_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam bit [7:0] NMI_V = 8'hF8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_n = 8'hFF;
    logic        nmi_n = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  esel = 8'h00;
    logic [63:0] vtbl = '0;
    logic        ack = 1'b0;
    logic        valid, nmi;
    logic [3:0]  src;
    logic [7:0]  vec;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_decoder #(.NMI_VECTOR(NMI_V)) dut_i (
        .clk(clk), .rst(rst), .irq_n_i(irq_n), .nmi_n_i(nmi_n), .mode_i(mode),
        .edge_sel_i(esel), .vec_tbl_i(vtbl), .ack_i(ack),
        .req_valid_o(valid), .req_nmi_o(nmi), .req_src_o(src), .req_vec_o(vec)
    );

    // Behavioural reference: pin history queues, newest sample first.
    bit [7:0] hist[$];
    bit       nhist[$];
    bit [7:0] m_pend;
    bit       m_npend;

    function automatic bit dedicated(int i);
        if (mode == 2'd1) return 0;
        if (mode == 2'd2) return i >= 5;
        return 1;
    endfunction

    function automatic void model_out(output bit v, output bit n,
                                      output bit [3:0] s, output bit [7:0] x);
        bit [7:0] low;
        bit [7:0] cand;
        bit       has;
        low = ~hist[1];
        v = 0; n = 0; s = 0; x = 0;
        for (int i = 0; i < 8; i++) begin
            if (dedicated(i) && (esel[i] ? m_pend[i] : low[i])) begin
                if (!v || vtbl[i*8 +: 8] >= x) begin
                    v = 1; s = 4'(i); x = vtbl[i*8 +: 8];
                end
            end
        end
        has = 0; cand = 0;
        if (mode == 2'd1) begin has = (low != 0); cand = low; end
        if (mode == 2'd2) begin has = (low[4:0] != 0); cand = {low[4:0], 3'b010}; end
        if (has && (!v || cand >= x)) begin v = 1; s = 4'd8; x = cand; end
        if (m_npend) begin v = 1; n = 1; s = 4'd9; x = NMI_V; end
    endfunction

    always @(posedge clk) begin
        bit ev, en;
        bit [3:0] es;
        bit [7:0] ex;
        bit [7:0] fall;
        if (rst) begin
            hist = '{8'hFF, 8'hFF, 8'hFF};
            nhist = '{1'b1, 1'b1, 1'b1};
            m_pend = 0;
            m_npend = 0;
        end else begin
            model_out(ev, en, es, ex);
            if (ack && ev) begin
                if (en) m_npend = 0;
                else if (es < 8) m_pend[es] = 0;
            end
            fall = hist[2] & ~hist[1];
            for (int i = 0; i < 8; i++)
                if (fall[i] && esel[i] && dedicated(i)) m_pend[i] = 1;
            if (nhist[2] && !nhist[1]) m_npend = 1;
            hist.push_front(irq_n);
            void'(hist.pop_back());
            nhist.push_front(nmi_n);
            void'(nhist.pop_back());
        end
    end

    always @(negedge clk) begin
        bit ev, en;
        bit [3:0] es;
        bit [7:0] ex;
        if (!rst && !done) begin
            model_out(ev, en, es, ex);
            checks++;
            if (valid !== ev || (ev && (nmi !== en || src !== es || vec !== ex))) begin
                fails++;
                $display("FAIL %s t=%0t actual v=%0b n=%0b src=%0d vec=%h expected v=%0b n=%0b src=%0d vec=%h",
                         tag, $time, valid, nmi, src, vec, ev, en, es, ex);
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        cyc();
        ack = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) vtbl[i*8 +: 8] = 8'(8'h20 + i * 8);
        cyc(3);
        rst = 1'b0;
        cyc();
        // R1: quiet after reset
        checks++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual valid=%0b expected 0", valid);
        end
        cyc(2);

        tag = "R3"; // level source, R2 latency checked each cycle
        esel = 8'b0000_1010;
        irq_n[0] = 1'b0; cyc(5);
        irq_n[0] = 1'b1; cyc(4);

        tag = "R4";
        irq_n[1] = 1'b0; cyc(3);
        irq_n[1] = 1'b1; cyc(6);

        tag = "R5";
        ack_pulse(); cyc(3);
        irq_n[0] = 1'b0; cyc(4);
        ack_pulse(); cyc(3);
        irq_n[0] = 1'b1; cyc(4);
        irq_n[1] = 1'b0; cyc(3); irq_n[1] = 1'b1; cyc(4);
        irq_n[1] = 1'b0; cyc(1);
        ack_pulse(); cyc(4);
        irq_n[1] = 1'b1; cyc(2);
        ack_pulse(); cyc(3);

        tag = "R8";
        irq_n[0] = 1'b0; irq_n[3] = 1'b0; cyc(2);
        irq_n[3] = 1'b1; cyc(4);
        vtbl[0 +: 8] = vtbl[24 +: 8]; cyc(3);
        ack_pulse(); cyc(3);
        irq_n[0] = 1'b1; vtbl[0 +: 8] = 8'h20; cyc(4);

        tag = "R9";
        irq_n[6] = 1'b0; esel[6] = 1'b1; cyc(2);
        nmi_n = 1'b0; cyc(3); nmi_n = 1'b1; cyc(4);
        ack_pulse(); cyc(3);
        ack_pulse(); cyc(3);
        irq_n[6] = 1'b1; cyc(4);

        tag = "R6";
        mode = 2'd1; esel = 8'hFF;
        irq_n = 8'hF5; cyc(5);
        irq_n = 8'hFF; cyc(5);
        irq_n = 8'h00; cyc(4);
        ack_pulse(); cyc(2);
        irq_n = 8'h7E; cyc(4);
        irq_n = 8'hFF; cyc(4);

        tag = "R7";
        mode = 2'd2; esel = 8'b1000_0000;
        irq_n = 8'hFF; cyc(3);
        irq_n[4:0] = 5'b11101; cyc(4);
        irq_n[7] = 1'b0; cyc(4);
        vtbl[56 +: 8] = 8'h08; cyc(3);
        irq_n[6] = 1'b0; cyc(4);
        ack_pulse(); cyc(3);
        irq_n = 8'hFF; cyc(4);
        ack_pulse(); cyc(3);

        tag = "R10";
        mode = 2'd3; esel = 8'h00;
        irq_n = 8'hEB; cyc(5);
        irq_n = 8'hFF; cyc(4);
        mode = 2'd0;
        irq_n[2] = 1'b0; cyc(4);
        irq_n = 8'hFF; cyc(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule